// File: doc/BRIEF.md
# Supervisor Trap State Unit

This block holds the supervisor-level trap state of a load/store core. When address translation rejects an instruction fetch, a load or a store, the core raises a fault request with the kind of access, the PC of the failing instruction and the virtual address that failed. At the next clock edge the unit records a cause code and both addresses in dedicated registers. It saves the interrupt-enable and privilege bits into the status register. One cycle later it issues a fetch redirect to the trap vector base.

Only the status bits are saved by hardware. The stack pointer is left alone, and the handler switches stacks in software. A trap-return input reverses the status save and redirects fetch to the saved exception PC, so the faulting instruction runs again. Software reads and writes all of these registers through a small CSR port. When a trap and a software write target the same register in the same cycle, the trap's value is the one kept.

Top module: `sup_trap_unit`

## Requirements
- R1: After reset the vector base reads RESET_VEC (default 0x100), the exception PC, cause, fault-address and status registers read 0, the mode is supervisor (`priv_o`=1), `irq_en_o` is 0 and no redirect is issued.
- R2: A fault request with `fault_kind_i` 0 (fetch) writes cause code 12, kind 1 (load) writes 13 and kind 2 (store) writes 15, zero-extended, at the clock edge where the request is sampled.
- R3: At that same edge the fault-address register takes `fault_addr_i` and the exception-PC register takes `fault_pc_i`.
- R4: In the cycle after an accepted fault, `redirect_valid_o` is 1 for exactly one cycle and `redirect_pc_o` equals the vector base as it stood before that edge.
- R5: On an accepted fault the previous-enable bit (status bit 1) takes the current enable bit (status bit 0), the current enable is cleared, the previous-privilege bit (status bit 2) takes the mode that trapped (1 supervisor, 0 user), and the mode becomes supervisor.
- R6: A trap-return with no fault in the same cycle redirects fetch in the next cycle to the exception PC, restores the mode from the previous-privilege bit and the current enable from the previous-enable bit, then sets previous-enable to 1 and previous-privilege to user.
- R7: In the same cycle, a fault beats a software write to the exception PC, cause, fault-address or status register, and beats a trap-return. A software write to the vector base in the same cycle still lands, but the redirect uses the old base.
- R8: A fault request with `fault_kind_i` 3 is ignored: no redirect, and no trap register or status bit changes.
- R9: CSR addresses are 0 status, 1 vector base, 2 exception PC, 3 cause, 4 fault address. Reads of other addresses return 0 and writes there change nothing. Vector-base bits 1:0 and status bits above 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_valid_i | input | 1 | Translation fault request |
| fault_kind_i | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved |
| fault_pc_i | input | XLEN | PC of the faulting instruction |
| fault_addr_i | input | XLEN | Virtual address that failed translation |
| tret_i | input | 1 | Trap-return request |
| csr_we_i | input | 1 | Software CSR write enable |
| csr_addr_i | input | CSR_AW | Software CSR address |
| csr_wdata_i | input | XLEN | Software CSR write data |
| csr_rdata_o | output | XLEN | Software CSR read data (combinational) |
| redirect_valid_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | XLEN | Fetch redirect target |
| priv_o | output | 1 | Current mode, 1 supervisor, 0 user |
| irq_en_o | output | 1 | Current interrupt-enable bit |

## Verification
Two things can reach the same register in one cycle: a fault capture and a software CSR write. A fault can also arrive together with a trap-return. The bench sets up each collision by raising the fault request in the same cycle as a write to the cause, status or vector-base register, or together with `tret_i`. It then reads the registers back and checks the redirect target. The fault's values must win everywhere except the vector base. There the write must land, but the redirect must still go to the old base.

// File: rtl/sup_trap_pkg.sv
// Shared constants for the supervisor trap state unit: fault kinds,
// cause codes, status bit positions, CSR addresses and field indices.
// Assumes a CSR address space of at least three bits.
package sup_trap_pkg;

    typedef enum logic [1:0] {
        FK_FETCH = 2'd0,
        FK_LOAD  = 2'd1,
        FK_STORE = 2'd2,
        FK_RSVD  = 2'd3
    } fault_kind_e;

    localparam int CODE_W = 5;
    localparam logic [CODE_W-1:0] CODE_FETCH_PF = 5'd12;
    localparam logic [CODE_W-1:0] CODE_LOAD_PF  = 5'd13;
    localparam logic [CODE_W-1:0] CODE_STORE_PF = 5'd15;

    // status register bit positions
    localparam int ST_IE    = 0;
    localparam int ST_PIE   = 1;
    localparam int ST_PPRIV = 2;
    localparam int ST_W     = 3;

    localparam logic PRIV_USER = 1'b0;
    localparam logic PRIV_SUP  = 1'b1;

    // CSR addresses seen by software
    localparam int A_STATUS = 0;
    localparam int A_VEC    = 1;
    localparam int A_EPC    = 2;
    localparam int A_CAUSE  = 3;
    localparam int A_TVAL   = 4;

    // indices of the data-field registers
    localparam int NFLD      = 4;
    localparam int FLD_VEC   = 0;
    localparam int FLD_EPC   = 1;
    localparam int FLD_CAUSE = 2;
    localparam int FLD_TVAL  = 3;

    // maps a field index to its software address
    function automatic int fld_addr(input int idx);
        case (idx)
            FLD_VEC:   return A_VEC;
            FLD_EPC:   return A_EPC;
            FLD_CAUSE: return A_CAUSE;
            default:   return A_TVAL;
        endcase
    endfunction

endpackage

// File: rtl/sup_trap_cause_enc.sv
// Turns a fault request into a take strobe and a zero-extended cause
// code. Assumes fault_kind_i is meaningful only while fault_valid_i is high;
// the reserved kind yields no take.
module sup_trap_cause_enc
    import sup_trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            fault_valid_i,
    input  logic [1:0]      fault_kind_i,
    output logic            take_o,
    output logic [XLEN-1:0] code_o
);

    logic [CODE_W-1:0] code_s;

    // select the code for the access kind and gate the take strobe
    always_comb begin
        code_s = '0;
        take_o = 1'b0;
        case (fault_kind_e'(fault_kind_i))
            FK_FETCH: begin code_s = CODE_FETCH_PF; take_o = fault_valid_i; end
            FK_LOAD:  begin code_s = CODE_LOAD_PF;  take_o = fault_valid_i; end
            FK_STORE: begin code_s = CODE_STORE_PF; take_o = fault_valid_i; end
            default:  begin code_s = '0;            take_o = 1'b0;          end
        endcase
    end

    assign code_o = {{(XLEN-CODE_W){1'b0}}, code_s};

endmodule

// File: rtl/sup_trap_field.sv
// One trap data register with two load sources: a hardware trap load, which
// has priority, and a masked software load. Assumes both loads are one-cycle
// strobes from the same clock domain.
module sup_trap_field #(
    parameter int           W     = 32,
    parameter logic [W-1:0] RST   = '0,
    parameter logic [W-1:0] WMASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trap_ld_i,
    input  logic [W-1:0] trap_val_i,
    input  logic         sw_ld_i,
    input  logic [W-1:0] sw_val_i,
    output logic [W-1:0] q_o
);

    // hold the value; the trap load beats the software load
    always_ff @(posedge clk) begin
        if (!rst_n)         q_o <= RST;
        else if (trap_ld_i) q_o <= trap_val_i;
        else if (sw_ld_i)   q_o <= sw_val_i & WMASK;
    end

endmodule

// File: rtl/sup_trap_status.sv
// The saved status bits and the current mode. The priority order is:
// trap entry, then trap return, then software write. Assumes the
// software write carries only the three status bits.
module sup_trap_status
    import sup_trap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_i,
    input  logic            tret_i,
    input  logic            sw_we_i,
    input  logic [ST_W-1:0] sw_val_i,
    output logic            ie_o,
    output logic            pie_o,
    output logic            ppriv_o,
    output logic            priv_o
);

    // update the enable and privilege state on trap, return or write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_o    <= 1'b0;
            pie_o   <= 1'b0;
            ppriv_o <= PRIV_USER;
            priv_o  <= PRIV_SUP;
        end else if (trap_i) begin
            pie_o   <= ie_o;
            ie_o    <= 1'b0;
            ppriv_o <= priv_o;
            priv_o  <= PRIV_SUP;
        end else if (tret_i) begin
            ie_o    <= pie_o;
            pie_o   <= 1'b1;
            ppriv_o <= PRIV_USER;
            priv_o  <= ppriv_o;
        end else if (sw_we_i) begin
            ie_o    <= sw_val_i[ST_IE];
            pie_o   <= sw_val_i[ST_PIE];
            ppriv_o <= sw_val_i[ST_PPRIV];
        end
    end

endmodule

// File: rtl/sup_trap_redirect.sv
// Registers the fetch redirect: a one-cycle strobe with the vector base on a
// trap, or the exception PC on a return. Assumes the caller has already
// given the trap priority over a return arriving in the same cycle.
module sup_trap_redirect #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_i,
    input  logic            tret_i,
    input  logic [XLEN-1:0] vec_i,
    input  logic [XLEN-1:0] epc_i,
    output logic            valid_o,
    output logic [XLEN-1:0] pc_o
);

    // raise the strobe for one cycle and latch the target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            pc_o    <= '0;
        end else begin
            valid_o <= trap_i | tret_i;
            if (trap_i)      pc_o <= vec_i;
            else if (tret_i) pc_o <= epc_i;
        end
    end

endmodule

// File: rtl/sup_trap_unit.sv
// Supervisor trap state unit. It captures the cause, fault address and
// return PC on a translation fault, saves the enable and privilege bits,
// and redirects fetch to the vector base. Trap-return restores that state.
// Software uses a CSR port with a combinational read. Assumes that fault
// and trap-return requests are single-cycle strobes.
module sup_trap_unit
    import sup_trap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              CSR_AW    = 3,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_valid_i,
    input  logic [1:0]        fault_kind_i,
    input  logic [XLEN-1:0]   fault_pc_i,
    input  logic [XLEN-1:0]   fault_addr_i,
    input  logic              tret_i,
    input  logic              csr_we_i,
    input  logic [CSR_AW-1:0] csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              redirect_valid_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic              priv_o,
    output logic              irq_en_o
);

    localparam logic [XLEN-1:0] VEC_MASK = {{(XLEN-2){1'b1}}, 2'b00};
    localparam logic [XLEN-1:0] ALL_ONES = {XLEN{1'b1}};

    logic            trap_take;
    logic [XLEN-1:0] trap_code;
    logic            tret_eff;
    logic            st_we;

    logic            trap_ld  [NFLD];
    logic [XLEN-1:0] trap_val [NFLD];
    logic            sw_ld    [NFLD];
    logic [XLEN-1:0] fld_q    [NFLD];

    logic [XLEN-1:0] vec_q, epc_q, cause_q, tval_q;
    logic            ie_q, pie_q, ppriv_q;

    sup_trap_cause_enc #(.XLEN(XLEN)) u_enc (
        .fault_valid_i (fault_valid_i),
        .fault_kind_i  (fault_kind_i),
        .take_o        (trap_take),
        .code_o        (trap_code)
    );

    // a return in the same cycle as a fault is dropped
    assign tret_eff = tret_i && !trap_take;
    assign st_we    = csr_we_i && (int'(csr_addr_i) == A_STATUS);

    // route the trap-time values to each data field
    always_comb begin
        trap_ld[FLD_VEC]    = 1'b0;
        trap_val[FLD_VEC]   = '0;
        trap_ld[FLD_EPC]    = trap_take;
        trap_val[FLD_EPC]   = fault_pc_i;
        trap_ld[FLD_CAUSE]  = trap_take;
        trap_val[FLD_CAUSE] = trap_code;
        trap_ld[FLD_TVAL]   = trap_take;
        trap_val[FLD_TVAL]  = fault_addr_i;
    end

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        localparam logic [XLEN-1:0] RSTV = (g == FLD_VEC) ? (RESET_VEC & VEC_MASK) : '0;
        localparam logic [XLEN-1:0] MSK  = (g == FLD_VEC) ? VEC_MASK : ALL_ONES;

        assign sw_ld[g] = csr_we_i && (int'(csr_addr_i) == fld_addr(g));

        sup_trap_field #(.W(XLEN), .RST(RSTV), .WMASK(MSK)) u_fld (
            .clk        (clk),
            .rst_n      (rst_n),
            .trap_ld_i  (trap_ld[g]),
            .trap_val_i (trap_val[g]),
            .sw_ld_i    (sw_ld[g]),
            .sw_val_i   (csr_wdata_i),
            .q_o        (fld_q[g])
        );
    end

    assign vec_q   = fld_q[FLD_VEC];
    assign epc_q   = fld_q[FLD_EPC];
    assign cause_q = fld_q[FLD_CAUSE];
    assign tval_q  = fld_q[FLD_TVAL];

    sup_trap_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .trap_i   (trap_take),
        .tret_i   (tret_eff),
        .sw_we_i  (st_we),
        .sw_val_i (csr_wdata_i[ST_W-1:0]),
        .ie_o     (ie_q),
        .pie_o    (pie_q),
        .ppriv_o  (ppriv_q),
        .priv_o   (priv_o)
    );

    assign irq_en_o = ie_q;

    sup_trap_redirect #(.XLEN(XLEN)) u_redir (
        .clk     (clk),
        .rst_n   (rst_n),
        .trap_i  (trap_take),
        .tret_i  (tret_eff),
        .vec_i   (vec_q),
        .epc_i   (epc_q),
        .valid_o (redirect_valid_o),
        .pc_o    (redirect_pc_o)
    );

    // software read mux; unmapped addresses read zero
    always_comb begin
        csr_rdata_o = '0;
        case (int'(csr_addr_i))
            A_STATUS: begin
                csr_rdata_o[ST_IE]    = ie_q;
                csr_rdata_o[ST_PIE]   = pie_q;
                csr_rdata_o[ST_PPRIV] = ppriv_q;
            end
            A_VEC:   csr_rdata_o = vec_q;
            A_EPC:   csr_rdata_o = epc_q;
            A_CAUSE: csr_rdata_o = cause_q;
            A_TVAL:  csr_rdata_o = tval_q;
            default: csr_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/sup_trap_chk.sv
// Assertion checker for sup_trap_unit, attached by bind. Assumes it sees the
// unit's ports and its internal trap registers.
module sup_trap_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fault_valid_i,
    input logic [1:0]      fault_kind_i,
    input logic [XLEN-1:0] fault_pc_i,
    input logic [XLEN-1:0] fault_addr_i,
    input logic            tret_i,
    input logic            redirect_valid_o,
    input logic [XLEN-1:0] redirect_pc_o,
    input logic            priv_o,
    input logic [XLEN-1:0] vec_q,
    input logic [XLEN-1:0] epc_q,
    input logic [XLEN-1:0] cause_q,
    input logic [XLEN-1:0] tval_q,
    input logic            ie_q,
    input logic            pie_q,
    input logic            ppriv_q
);

    logic take;
    assign take = fault_valid_i && (fault_kind_i != 2'd3);

    // R2
    fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid_i && fault_kind_i == 2'd0) |=> cause_q == XLEN'(12));
    // R2
    load_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid_i && fault_kind_i == 2'd1) |=> cause_q == XLEN'(13));
    // R2
    store_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid_i && fault_kind_i == 2'd2) |=> cause_q == XLEN'(15));
    // R3
    addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (tval_q == $past(fault_addr_i)) && (epc_q == $past(fault_pc_i)));
    // R4
    vector_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> redirect_valid_o && (redirect_pc_o == $past(vec_q)));
    // R4
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !tret_i) |=> !redirect_valid_o);
    // R5
    status_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !ie_q && (pie_q == $past(ie_q)) && (ppriv_q == $past(priv_o)) && priv_o);
    // R6
    return_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tret_i && !take) |=> redirect_valid_o && (redirect_pc_o == $past(epc_q))
                              && (priv_o == $past(ppriv_q)) && (ie_q == $past(pie_q))
                              && pie_q && !ppriv_q);
    // R8
    reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid_i && fault_kind_i == 2'd3 && !tret_i) |=> !redirect_valid_o);
    // R9
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_q[1:0] == 2'b00);

endmodule

bind sup_trap_unit sup_trap_chk #(.XLEN(XLEN)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .fault_valid_i    (fault_valid_i),
    .fault_kind_i     (fault_kind_i),
    .fault_pc_i       (fault_pc_i),
    .fault_addr_i     (fault_addr_i),
    .tret_i           (tret_i),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o),
    .priv_o           (priv_o),
    .vec_q            (vec_q),
    .epc_q            (epc_q),
    .cause_q          (cause_q),
    .tval_q           (tval_q),
    .ie_q             (ie_q),
    .pie_q            (pie_q),
    .ppriv_q          (ppriv_q)
);

// File: tb/tb_sup_trap_unit.sv
// Bench for sup_trap_unit. It walks a table of fault vectors, then runs
// directed tests for reset, the CSR port, trap return and same-cycle
// collisions. Inputs change on the falling edge and outputs are sampled there.
module tb_sup_trap_unit;

    localparam int PERIOD = 10;
    localparam int XLEN   = 32;
    localparam int AW     = 3;
    localparam int AD_ST = 0, AD_VEC = 1, AD_EPC = 2, AD_CAUSE = 3, AD_TVAL = 4;

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] pc;
        logic [31:0] addr;
        logic [31:0] code;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h0000_1000, 32'h0000_1000, 32'd12},
        '{2'd1, 32'h0000_1004, 32'hDEAD_BEE0, 32'd13},
        '{2'd2, 32'h0000_1008, 32'h8000_0004, 32'd15},
        '{2'd2, 32'hFFFF_FFFC, 32'h0000_0000, 32'd15},
        '{2'd1, 32'h0000_0002, 32'hFFFF_FFFF, 32'd13},
        '{2'd0, 32'h7FFF_FFFE, 32'h7FFF_FFFE, 32'd12}
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic            fault_valid_i;
    logic [1:0]      fault_kind_i;
    logic [XLEN-1:0] fault_pc_i, fault_addr_i;
    logic            tret_i, csr_we_i;
    logic [AW-1:0]   csr_addr_i;
    logic [XLEN-1:0] csr_wdata_i, csr_rdata_o;
    logic            redirect_valid_o;
    logic [XLEN-1:0] redirect_pc_o;
    logic            priv_o, irq_en_o;

    int n_vec = 0;
    int n_bad = 0;

    // bench model of the architectural state
    logic        m_ie = 1'b0, m_pie = 1'b0, m_ppriv = 1'b0, m_priv = 1'b1;
    logic [31:0] m_vec = 32'h100, m_epc = '0, m_cause = '0, m_tval = '0;

    always #(PERIOD/2) clk = ~clk;

    sup_trap_unit dut (
        .clk(clk), .rst_n(rst_n),
        .fault_valid_i(fault_valid_i), .fault_kind_i(fault_kind_i),
        .fault_pc_i(fault_pc_i), .fault_addr_i(fault_addr_i),
        .tret_i(tret_i), .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i),
        .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
        .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
        .priv_o(priv_o), .irq_en_o(irq_en_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        csr_addr_i = AW'(a);
        #1;
        d = csr_rdata_o;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        csr_we_i = 1'b1; csr_addr_i = AW'(a); csr_wdata_i = d;
        @(negedge clk);
        csr_we_i = 1'b0;
    endtask

    function automatic logic [31:0] m_status();
        return {29'd0, m_ppriv, m_pie, m_ie};
    endfunction

    task automatic model_trap(input logic [31:0] pc, input logic [31:0] addr, input logic [31:0] code);
        m_pie = m_ie; m_ie = 1'b0; m_ppriv = m_priv; m_priv = 1'b1;
        m_epc = pc; m_tval = addr; m_cause = code;
    endtask

    // compare every readable register and the mode outputs with the model
    task automatic chk_state(input string tag);
        logic [31:0] d;
        rd(AD_ST, d);    chk({tag, " status"}, d, m_status());
        rd(AD_CAUSE, d); chk({tag, " cause"}, d, m_cause);
        rd(AD_EPC, d);   chk({tag, " epc"}, d, m_epc);
        rd(AD_TVAL, d);  chk({tag, " tval"}, d, m_tval);
        rd(AD_VEC, d);   chk({tag, " vecbase"}, d, m_vec);
        chk({tag, " priv_o"}, {31'd0, priv_o}, {31'd0, m_priv});
        chk({tag, " irq_en_o"}, {31'd0, irq_en_o}, {31'd0, m_ie});
    endtask

    // watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got=hang exp=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] old_vec;
        rst_n = 1'b0; fault_valid_i = 1'b0; fault_kind_i = '0;
        fault_pc_i = '0; fault_addr_i = '0; tret_i = 1'b0;
        csr_we_i = 1'b0; csr_addr_i = '0; csr_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 redirect_valid", {31'd0, redirect_valid_o}, 32'd0);
        chk_state("R1");

        // R9: vector base alignment, unmapped address, status width
        wr(AD_VEC, 32'h0000_2003);
        m_vec = 32'h0000_2000;
        rd(AD_VEC, d); chk("R9 vecbase low bits", d, 32'h0000_2000);
        wr(7, 32'hFFFF_FFFF);
        rd(7, d); chk("R9 unmapped read", d, 32'd0);
        chk_state("R9 unmapped write");
        wr(AD_ST, 32'hFFFF_FFFA);
        m_pie = 1'b1;
        rd(AD_ST, d); chk("R9 status width", d, 32'h0000_0002);
        wr(AD_EPC, 32'h0000_4000);
        m_epc = 32'h0000_4000;

        // R6: return to user mode
        @(negedge clk); tret_i = 1'b1;
        @(negedge clk); tret_i = 1'b0;
        m_ie = m_pie; m_pie = 1'b1; m_priv = m_ppriv; m_ppriv = 1'b0;
        chk("R6 redirect_valid", {31'd0, redirect_valid_o}, 32'd1);
        chk("R6 redirect pc", redirect_pc_o, 32'h0000_4000);
        chk_state("R6 return");

        // R2 R3 R4 R5: table of fault vectors
        for (int i = 0; i < NV; i++) begin
            if (i == 3) begin
                wr(AD_ST, 32'h1);
                m_ie = 1'b1; m_pie = 1'b0; m_ppriv = 1'b0;
            end
            @(negedge clk);
            fault_valid_i = 1'b1; fault_kind_i = VECS[i].kind;
            fault_pc_i = VECS[i].pc; fault_addr_i = VECS[i].addr;
            @(negedge clk);
            fault_valid_i = 1'b0;
            model_trap(VECS[i].pc, VECS[i].addr, VECS[i].code);
            chk("R4 redirect_valid", {31'd0, redirect_valid_o}, 32'd1);
            chk("R4 redirect pc", redirect_pc_o, m_vec);
            chk_state("R2 R3 R5 vector");
            @(negedge clk);
            chk("R4 single pulse", {31'd0, redirect_valid_o}, 32'd0);
        end

        // R7: trap against a write to cause, then to status
        @(negedge clk);
        fault_valid_i = 1'b1; fault_kind_i = 2'd1;
        fault_pc_i = 32'h0000_0A00; fault_addr_i = 32'h0000_0B00;
        csr_we_i = 1'b1; csr_addr_i = AW'(AD_CAUSE); csr_wdata_i = 32'h55;
        @(negedge clk);
        fault_valid_i = 1'b0; csr_we_i = 1'b0;
        model_trap(32'h0000_0A00, 32'h0000_0B00, 32'd13);
        chk_state("R7 cause collision");

        wr(AD_ST, 32'h1);
        m_ie = 1'b1; m_pie = 1'b0; m_ppriv = 1'b0;
        @(negedge clk);
        fault_valid_i = 1'b1; fault_kind_i = 2'd2;
        fault_pc_i = 32'h0000_0C00; fault_addr_i = 32'h0000_0D00;
        csr_we_i = 1'b1; csr_addr_i = AW'(AD_ST); csr_wdata_i = 32'h7;
        @(negedge clk);
        fault_valid_i = 1'b0; csr_we_i = 1'b0;
        model_trap(32'h0000_0C00, 32'h0000_0D00, 32'd15);
        chk_state("R7 status collision");

        // R7: trap against a write to the vector base
        old_vec = m_vec;
        @(negedge clk);
        fault_valid_i = 1'b1; fault_kind_i = 2'd0;
        fault_pc_i = 32'h0000_0E00; fault_addr_i = 32'h0000_0E00;
        csr_we_i = 1'b1; csr_addr_i = AW'(AD_VEC); csr_wdata_i = 32'h0000_3000;
        @(negedge clk);
        fault_valid_i = 1'b0; csr_we_i = 1'b0;
        model_trap(32'h0000_0E00, 32'h0000_0E00, 32'd12);
        m_vec = 32'h0000_3000;
        chk("R7 redirect uses old base", redirect_pc_o, old_vec);
        chk_state("R7 vecbase collision");

        // R7: trap and trap-return together
        @(negedge clk);
        fault_valid_i = 1'b1; fault_kind_i = 2'd1; tret_i = 1'b1;
        fault_pc_i = 32'h0000_0F00; fault_addr_i = 32'h0000_0F04;
        @(negedge clk);
        fault_valid_i = 1'b0; tret_i = 1'b0;
        model_trap(32'h0000_0F00, 32'h0000_0F04, 32'd13);
        chk("R7 trap beats return pc", redirect_pc_o, m_vec);
        chk_state("R7 trap with return");

        // R8: reserved kind changes nothing
        @(negedge clk);
        fault_valid_i = 1'b1; fault_kind_i = 2'd3;
        fault_pc_i = 32'h1234_5678; fault_addr_i = 32'h9ABC_DEF0;
        @(negedge clk);
        fault_valid_i = 1'b0;
        chk("R8 no redirect", {31'd0, redirect_valid_o}, 32'd0);
        chk_state("R8 reserved kind");

        // R6: return to supervisor
        wr(AD_EPC, 32'h0000_5550);
        m_epc = 32'h0000_5550;
        @(negedge clk); tret_i = 1'b1;
        @(negedge clk); tret_i = 1'b0;
        m_ie = m_pie; m_pie = 1'b1; m_priv = m_ppriv; m_ppriv = 1'b0;
        chk("R6 redirect pc supervisor", redirect_pc_o, 32'h0000_5550);
        chk_state("R6 return to supervisor");

        // R1: reset again after activity
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_ie = 1'b0; m_pie = 1'b0; m_ppriv = 1'b0; m_priv = 1'b1;
        m_vec = 32'h100; m_epc = '0; m_cause = '0; m_tval = '0;
        chk("R1 redirect after reset", {31'd0, redirect_valid_o}, 32'd0);
        chk_state("R1 second reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule